// File: doc/BRIEF.md
# Transport Clock Reference Capture Unit

This unit watches an MPEG-2 transport stream delivered one byte per accepted cycle. When a packet holds an adaptation field that carries a program clock reference, it stores the 33-bit base and 9-bit extension in host-readable registers. In the same clock it copies a free-running local cycle counter into a snapshot register, and it raises an arrival flag. The flag drops when the host reads the status register.

The host compares successive pairs of reference and snapshot values to estimate the frequency offset between the encoder and the local clock. It then writes a 16-bit correction word. A first-order sigma-delta modulator turns that word into a one-bit stream whose density of ones is word/65536. After an external low-pass filter, this stream steers a voltage-controlled crystal oscillator.

Top module: `tsclk_ref_capture`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pcr_base`, `pcr_ext`, `lc_snap`, `pcr_arrived` and `sd_out` are all 0.
- R2: A packet is opened by a byte accepted with `in_start` high whose value is 0x47. Its bytes are numbered from 0. A capture takes place when all of the following hold: bit 5 of byte 3 is 1 (control field in bits 5:4 equal to 10 or 11), byte 4 (field length) is at least 7, and bit 4 of byte 5 is 1. The base is then bytes 6..9 followed by bit 7 of byte 10, most significant first. The extension is bit 0 of byte 10 followed by byte 11. Both values appear on the outputs in the clock after byte 11 is accepted.
- R3: No capture takes place, and all three stored values stay unchanged, when the control field is 00 or 01, when the length byte is below 7, when bit 4 of byte 5 is 0, or when the opening byte is not 0x47.
- R4: The local counter is 0 in the first cycle after reset and increases by one every clock. On a capture, `lc_snap` takes the value the counter held in the cycle in which byte 11 was accepted.
- R5: `pcr_arrived` is 1 in the clock after a capture.
- R6: A cycle with `host_stat_rd` high and no capture clears `pcr_arrived` in the next clock. The flag falls only after such a read.
- R7: When a capture and a read fall in the same cycle, the flag stays 1. A capture while the flag is still set overwrites all stored values, and the flag stays 1.
- R8: Cycles with `in_valid` low are ignored. Gaps between bytes do not change byte numbering.
- R9: A new opening byte abandons a partial packet, so values from the abandoned packet are never stored. Bytes that arrive after the 188th byte, and bytes that arrive with no packet open, are ignored.
- R10: `sd_out` is the registered carry out of a 16-bit accumulator that adds `host_err` every clock. With a constant word, exactly `host_err` ones appear in any 65536 consecutive clocks, and a word of 0 gives all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte present this cycle |
| in_start | input | 1 | Byte is the first of a packet |
| in_byte | input | 8 | Stream byte |
| host_stat_rd | input | 1 | Host reads the status register this cycle |
| host_err | input | 16 | Host correction word for the modulator |
| pcr_base | output | 33 | Stored reference base |
| pcr_ext | output | 9 | Stored reference extension |
| lc_snap | output | 32 | Local counter snapshot |
| pcr_arrived | output | 1 | Arrival flag, cleared by a read |
| sd_out | output | 1 | Modulator bit stream |

## Verification
Four properties are checked on every cycle: the flag sets after a capture, it clears after a read with no capture, it falls only after a read, and the stored values change only on a capture. A zero correction word must also give a zero stream. Only the bench scenarios can show which header patterns qualify, where the reference bits are taken from, the exact snapshot count, the effect of gaps and packet restarts, and the exact density of ones over a full accumulator period. The bench runs its own model of the unit and compares every output on each clock.

// File: rtl/tsclk_ref_capture.sv
module tsclk_ref_capture #(
  parameter int         LCW       = 32,
  parameter int         SDW       = 16,
  parameter int         PKT_LEN   = 188,
  parameter logic [7:0] SYNC_BYTE = 8'h47
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_start,
  input  logic [7:0]      in_byte,
  input  logic            host_stat_rd,
  input  logic [SDW-1:0]  host_err,
  output logic [32:0]     pcr_base,
  output logic [8:0]      pcr_ext,
  output logic [LCW-1:0]  lc_snap,
  output logic            pcr_arrived,
  output logic            sd_out
);
  localparam int IW = $clog2(PKT_LEN + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(PKT_LEN - 1);
  localparam logic [IW-1:0] IDX_CTRL = IW'(3);
  localparam logic [IW-1:0] IDX_LEN  = IW'(4);
  localparam logic [IW-1:0] IDX_FLG  = IW'(5);
  localparam logic [IW-1:0] IDX_P0   = IW'(6);
  localparam logic [IW-1:0] IDX_P4   = IW'(10);
  localparam logic [IW-1:0] IDX_END  = IW'(11);

  logic          active;
  logic [IW-1:0] idx;
  logic          af_on, len_ok, pcr_on;
  logic [39:0]   sh;
  logic [LCW-1:0] lc_cnt;
  logic [SDW-1:0] acc;
  logic [SDW:0]   sd_sum;
  logic          body, cap_fire;

  assign body     = in_valid && !in_start && active;
  assign cap_fire = body && idx == IDX_END && af_on && len_ok && pcr_on;
  assign sd_sum   = {1'b0, acc} + {1'b0, host_err};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      af_on  <= 1'b0;
      len_ok <= 1'b0;
      pcr_on <= 1'b0;
      sh     <= '0;
    end else if (in_valid && in_start) begin
      active <= in_byte == SYNC_BYTE;
      idx    <= IW'(1);
      af_on  <= 1'b0;
      len_ok <= 1'b0;
      pcr_on <= 1'b0;
    end else if (body) begin
      idx <= idx + 1'b1;
      if (idx == LAST_IDX) active <= 1'b0;
      if (idx == IDX_CTRL) af_on  <= in_byte[5];
      if (idx == IDX_LEN)  len_ok <= in_byte >= 8'd7;
      if (idx == IDX_FLG)  pcr_on <= in_byte[4];
      if (idx >= IDX_P0 && idx <= IDX_P4) sh <= {sh[31:0], in_byte};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_cnt      <= '0;
      lc_snap     <= '0;
      pcr_base    <= '0;
      pcr_ext     <= '0;
      pcr_arrived <= 1'b0;
    end else begin
      lc_cnt <= lc_cnt + 1'b1;
      if (cap_fire) begin
        pcr_base    <= {sh[39:8], sh[7]};
        pcr_ext     <= {sh[0], in_byte};
        lc_snap     <= lc_cnt;
        pcr_arrived <= 1'b1;
      end else if (host_stat_rd) begin
        pcr_arrived <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      sd_out <= 1'b0;
    end else begin
      acc    <= sd_sum[SDW-1:0];
      sd_out <= sd_sum[SDW];
    end
  end
endmodule

// File: rtl/tsclk_ref_capture_chk.sv
module tsclk_ref_capture_chk #(
  parameter int LCW = 32,
  parameter int SDW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cap_fire,
  input logic           host_stat_rd,
  input logic           pcr_arrived,
  input logic [32:0]    pcr_base,
  input logic [8:0]     pcr_ext,
  input logic [LCW-1:0] lc_snap,
  input logic [SDW-1:0] host_err,
  input logic           sd_out
);
  assert_set_on_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> pcr_arrived);

  assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stat_rd && !cap_fire) |=> !pcr_arrived);

  assert_fall_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pcr_arrived) |-> $past(host_stat_rd));

  assert_hold_values_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> ($stable(pcr_base) && $stable(pcr_ext) && $stable(lc_snap)));

  assert_zero_density_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_err == '0) |=> !sd_out);
endmodule

bind tsclk_ref_capture tsclk_ref_capture_chk #(.LCW(LCW), .SDW(SDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_fire(cap_fire), .host_stat_rd(host_stat_rd),
  .pcr_arrived(pcr_arrived), .pcr_base(pcr_base), .pcr_ext(pcr_ext),
  .lc_snap(lc_snap), .host_err(host_err), .sd_out(sd_out)
);

// File: tb/tb_tsclk_ref_capture.sv
module tb_tsclk_ref_capture;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_start = 0, host_stat_rd = 0;
  logic [7:0] in_byte = 0;
  logic [15:0] host_err = 0;
  logic [32:0] pcr_base;
  logic [8:0] pcr_ext;
  logic [31:0] lc_snap;
  logic pcr_arrived, sd_out;

  tsclk_ref_capture dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit chk_en = 0, done = 0;

  // behavioural reference model
  bit m_active; int m_idx; logic [7:0] m_pk [0:11];
  logic [32:0] m_base; logic [8:0] m_ext; logic [31:0] m_lc, m_snap;
  bit m_arr, m_sd; int m_acc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_idx = 0; m_base = 0; m_ext = 0; m_lc = 0; m_snap = 0;
      m_arr = 0; m_sd = 0; m_acc = 0;
    end else begin
      bit cap; int sum;
      cap = 0;
      if (in_valid) begin
        if (in_start) begin m_active = (in_byte == 8'h47); m_idx = 1; end
        else if (m_active) begin
          if (m_idx < 12) m_pk[m_idx] = in_byte;
          if (m_idx == 11 && m_pk[3][5] && m_pk[4] >= 7 && m_pk[5][4]) cap = 1;
          m_idx++;
          if (m_idx == 188) m_active = 0;
        end
      end
      if (cap) begin
        m_base = {m_pk[6], m_pk[7], m_pk[8], m_pk[9], m_pk[10][7]};
        m_ext = {m_pk[10][0], m_pk[11]};
        m_snap = m_lc; m_arr = 1;
      end else if (host_stat_rd) m_arr = 0;
      m_lc++;
      sum = m_acc + int'(host_err);
      m_sd = sum >= 65536; m_acc = sum % 65536;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %0h expected %0h", tag, act, exp); end
  endtask

  always @(negedge clk) if (chk_en && !done) begin
    chk(pcr_base == m_base, "R2 base", pcr_base, m_base);
    chk(pcr_ext == m_ext, "R2 ext", pcr_ext, m_ext);
    chk(lc_snap == m_snap, "R4 snapshot", lc_snap, m_snap);
    chk(pcr_arrived == m_arr, "R6 flag", pcr_arrived, m_arr);
    chk(sd_out == m_sd, "R10 sd_out", sd_out, m_sd);
  end

  task automatic cyc(input bit v, input bit st, input logic [7:0] b, input bit rd);
    @(negedge clk); #1;
    in_valid = v; in_start = st; in_byte = b; host_stat_rd = rd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0);
  endtask

  task automatic packet(input logic [7:0] sync, input logic [1:0] afc, input logic [7:0] len,
                        input logic [7:0] flg, input logic [32:0] b, input logic [8:0] e,
                        input bit gaps, input bit rd_at_end, input int nbytes);
    logic [7:0] p [0:11];
    p[0] = sync; p[1] = 8'h40; p[2] = 8'h21; p[3] = {2'b00, afc, 4'h3};
    p[4] = len; p[5] = flg; p[6] = b[32:25]; p[7] = b[24:17]; p[8] = b[16:9];
    p[9] = b[8:1]; p[10] = {b[0], 6'h3F, e[8]}; p[11] = e[7:0];
    for (int i = 0; i < nbytes; i++) begin
      cyc(1, i == 0, (i < 12) ? p[i] : 8'hA5, rd_at_end && i == 11);
      if (gaps && (i % 2 == 1)) idle(2);
    end
    idle(2);
  endtask

  task automatic read_stat();
    cyc(0, 0, 8'h00, 1); idle(1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual running expected finished");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ones;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 first cycle after reset
    chk(pcr_base == 0 && pcr_ext == 0 && lc_snap == 0, "R1 values", {pcr_base, pcr_ext}, 0);
    chk(!pcr_arrived && !sd_out, "R1 flags", {pcr_arrived, sd_out}, 0);
    chk_en = 1;
    // R2 R5 basic capture, afc 11
    packet(8'h47, 2'b11, 8'd7, 8'h10, 33'h1_2345_6789, 9'h155, 0, 0, 20);
    chk(pcr_base == 33'h1_2345_6789, "R2 direct base", pcr_base, 33'h1_2345_6789);
    chk(pcr_ext == 9'h155, "R2 direct ext", pcr_ext, 9'h155);
    chk(pcr_arrived, "R5 flag after capture", pcr_arrived, 1);
    read_stat();
    chk(!pcr_arrived, "R6 cleared by read", pcr_arrived, 0);
    // R3 non-qualifying packets
    packet(8'h47, 2'b01, 8'd7, 8'h10, 33'h0_AAAA_AAAA, 9'h0AA, 0, 0, 20);
    packet(8'h47, 2'b00, 8'd7, 8'h10, 33'h0_BBBB_BBBB, 9'h0BB, 0, 0, 20);
    packet(8'h47, 2'b11, 8'd6, 8'h10, 33'h0_CCCC_CCCC, 9'h0CC, 0, 0, 20);
    packet(8'h47, 2'b10, 8'd9, 8'hEF, 33'h0_DDDD_DDDD, 9'h0DD, 0, 0, 20);
    packet(8'h46, 2'b11, 8'd7, 8'h10, 33'h0_EEEE_EEEE, 9'h0EE, 0, 0, 20);
    chk(pcr_base == 33'h1_2345_6789 && !pcr_arrived, "R3 unchanged", pcr_base, 33'h1_2345_6789);
    // R8 afc 10 with gaps
    packet(8'h47, 2'b10, 8'd183, 8'h50, 33'h0_F00D_1357, 9'h1FF, 1, 0, 188);
    chk(pcr_base == 33'h0_F00D_1357 && pcr_ext == 9'h1FF, "R8 gapped capture", pcr_ext, 9'h1FF);
    read_stat();
    // R9 abandoned partial packet then trailing bytes
    packet(8'h47, 2'b11, 8'd7, 8'h10, 33'h1_1111_1111, 9'h111, 0, 0, 9);
    packet(8'h47, 2'b01, 8'd7, 8'h10, 33'h0_2222_2222, 9'h022, 0, 0, 188);
    for (int i = 0; i < 100; i++) cyc(1, 0, 8'hFF, 0);
    idle(2);
    chk(pcr_base == 33'h0_F00D_1357 && !pcr_arrived, "R9 nothing stored", pcr_base, 33'h0_F00D_1357);
    // R7 capture and read in same cycle, then overwrite while set
    packet(8'h47, 2'b11, 8'd7, 8'h10, 33'h0_3333_4444, 9'h033, 0, 1, 20);
    chk(pcr_arrived, "R7 capture beats read", pcr_arrived, 1);
    packet(8'h47, 2'b11, 8'd7, 8'h10, 33'h1_5555_6666, 9'h166, 0, 0, 20);
    chk(pcr_base == 33'h1_5555_6666 && pcr_arrived, "R7 overwrite", pcr_base, 33'h1_5555_6666);
    read_stat();
    // R4 snapshot is checked by model each clock; R10 densities
    host_err = 16'h0000; idle(40);
    host_err = 16'h4000; idle(4);
    ones = 0;
    for (int i = 0; i < 65536; i++) begin @(negedge clk); ones += sd_out; end
    chk(ones == 16384, "R10 density 0x4000", ones, 16384);
    host_err = 16'hFFFF; idle(4);
    ones = 0;
    for (int i = 0; i < 65536; i++) begin @(negedge clk); ones += sd_out; end
    chk(ones == 65535, "R10 density 0xFFFF", ones, 65535);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule